// File: doc/BRIEF.md
# SDRAM Mode Register and Read-Latency Burst Engine

This block is the device-side command core of a synchronous DRAM model. It takes a registered command, a bank and address word, and write data. A mode-load command stores the burst length, read latency, operating mode and write-burst policy, all decoded from the address word. A read or write command then starts a burst that walks the column addresses of a small on-chip array, one beat per clock.

Read data goes through a short pipeline. It leaves on the data output after the programmed latency of two or three clocks. A drive enable opens one clock before the first beat and closes one clock after the last. When a new read arrives during a running read burst, the old burst is cut short and the new one follows directly, with no gap in the drive enable. Writes take one data word per clock for the whole burst. When the write-burst policy bit is set, a write touches only its own column, while reads keep the programmed burst length. A sticky error output reports a mode load that contained a reserved setting.

Top module: `sdr_burst_core`

## Requirements
- R1: Command codes on `cmd_i` are 0 idle, 1 mode load, 2 read and 3 write. Mode-word bits are [2:0] burst code, [6:4] latency code, [8:7] operating mode and [9] write policy; bit 3 is not decoded. After reset the burst is 1 beat, the latency is 2, write bursts are on, and `mode_err_o`, `dq_valid_o`, `dq_oe_o` and `arr_we_o` are 0.
- R2: Latency code 010 selects 2 clocks and 011 selects 3. Any other latency code sets `mode_err_o` one clock after the load and keeps the previous latency.
- R3: Burst codes 000, 001, 010 and 011 select 1, 2, 4 and 8 beats. Codes with bit 2 set raise `mode_err_o` and keep the previous burst length.
- R4: A load whose operating-mode bits are not 00 changes no setting and sets `mode_err_o`. A load with every field legal clears it. The flag holds between loads.
- R5: For a read sampled at clock edge n with latency m, `dq_valid_o` is high and `dq_o` carries the first beat after edge n+m. One beat follows per clock.
- R6: `dq_oe_o` rises after edge n+m-1, stays high while beats are valid, and falls one clock after the last beat when no further read follows.
- R7: Beat j of a burst of length L starting at column c uses column (c & ~(L-1)) | ((c+j) & (L-1)). The bank part of `arr_addr_o` holds the command's bank.
- R8: For a write sampled at edge n, the word on `wdata_i` at edge n+j goes to beat j. `arr_we_o` is high after edge n+j for each beat, with `arr_addr_o` = {bank, column}.
- R9: With write-policy bit 9 set, a write performs exactly one beat at its own column. Reads still run the programmed burst length.
- R10: A read sampled while a read burst is running ends the old burst at once. The old beats already issued are still delivered, then the new beats follow at the programmed latency, and `dq_oe_o` stays high across the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 2 | Registered command code |
| bank_i | input | BANK_W | Bank select for read and write |
| addr_i | input | ADDR_W | Mode word on load, start column on read and write |
| wdata_i | input | DATA_W | Write data, one word per beat |
| arr_addr_o | output | BANK_W+COL_W | Array location of the current beat |
| arr_we_o | output | 1 | Array write strobe for the current beat |
| dq_o | output | DATA_W | Read data |
| dq_valid_o | output | 1 | Read data valid strobe |
| dq_oe_o | output | 1 | Data-bus drive enable |
| mode_err_o | output | 1 | Last mode load contained a reserved setting |

## Verification
`mode_err_o` is due one clock after a load. `arr_we_o` and `arr_addr_o` for write beat j are due one clock after the edge that samples the command, plus j. `dq_oe_o` is due m-1 clocks after the read, and `dq_valid_o` with `dq_o` m clocks after it. The bench drives and samples on the falling edge. It counts rising edges from the one that sampled the command, and compares every cycle of each burst window against these offsets: the cycle before the drive enable opens, each valid beat, and the first cycle after the drive enable closes. Expected read data comes from a bench-side copy of everything the bench has written, with addresses taken from the wrap rule in R7.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_LOAD  = 2'd1,
    CMD_READ  = 2'd2,
    CMD_WRITE = 2'd3
  } cmd_e;

  localparam int MODE_W = 10;

  typedef struct packed {
    logic       wr_single;
    logic       cl3;
    logic [2:0] bl_mask;
  } mode_t;

  function automatic logic [2:0] bl_to_mask(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd0;
      2'd1:    return 3'd1;
      2'd2:    return 3'd3;
      default: return 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [sdr_pkg::MODE_W-1:0] word,
  output sdr_pkg::mode_t           mode,
  output logic                     err
);
  import sdr_pkg::*;

  logic [2:0] bl_code;
  logic [2:0] cl_code;
  logic [1:0] op_code;
  logic       wb_bit;
  logic       unused_order;
  logic       bl_ok, cl_ok, op_ok;

  assign bl_code      = word[2:0];
  assign unused_order = word[3];
  assign cl_code      = word[6:4];
  assign op_code      = word[8:7];
  assign wb_bit       = word[9];

  always_comb begin
    bl_ok = (bl_code[2] == 1'b0);
    cl_ok = (cl_code == 3'b010) || (cl_code == 3'b011);
    op_ok = (op_code == 2'b00);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode.wr_single <= 1'b0;
      mode.cl3       <= 1'b0;
      mode.bl_mask   <= 3'd0;
      err            <= 1'b0;
    end else if (load) begin
      err <= !(bl_ok && cl_ok && op_ok);
      if (op_ok) begin
        mode.wr_single <= wb_bit;
        if (cl_ok) mode.cl3     <= cl_code[0];
        if (bl_ok) mode.bl_mask <= bl_to_mask(bl_code[1:0]);
      end
    end
  end

  // R2: illegal latency code leaves the latency untouched
  p_cl_keep_r2: assert property (@(posedge clk) disable iff (rst)
    (load && !cl_ok) |=> (mode.cl3 == $past(mode.cl3)));

  // R3: reserved burst code leaves the burst length untouched
  p_bl_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (load && !bl_ok) |=> (mode.bl_mask == $past(mode.bl_mask)));

  // R4: reserved operating mode rejects the whole load and flags it
  p_op_reject_r4: assert property (@(posedge clk) disable iff (rst)
    (load && !op_ok) |=> (err && mode == $past(mode)));

  // R4: fully legal load clears the flag
  p_err_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (load && bl_ok && cl_ok && op_ok) |=> !err);

  // R4: flag only moves on a load
  p_err_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !load |=> (err == $past(err)));

endmodule

// File: rtl/sdr_burst_gen.sv
module sdr_burst_gen #(
  parameter int BANK_W = 2,
  parameter int COL_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_rd,
  input  logic              start_wr,
  input  logic [BANK_W-1:0] bank_in,
  input  logic [COL_W-1:0]  col_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [2:0]        bl_mask,
  input  logic              wr_single,
  output logic [BANK_W-1:0] bank_q,
  output logic [COL_W-1:0]  col_q,
  output logic [DATA_W-1:0] wd_q,
  output logic              rd_issue,
  output logic              wr_issue
);

  logic             active;
  logic             is_wr;
  logic [2:0]       mask_q;
  logic [2:0]       left;
  logic [2:0]       start_mask;
  logic [COL_W-1:0] mext;
  logic [COL_W-1:0] next_col;

  assign start_mask = (start_wr && wr_single) ? 3'd0 : bl_mask;
  assign mext       = COL_W'(mask_q);
  assign next_col   = (col_q & ~mext) | ((col_q + 1'b1) & mext);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      is_wr  <= 1'b0;
      mask_q <= 3'd0;
      left   <= 3'd0;
      bank_q <= '0;
      col_q  <= '0;
      wd_q   <= '0;
    end else begin
      wd_q <= wdata_in;
      if (start_rd || start_wr) begin
        active <= 1'b1;
        is_wr  <= start_wr;
        bank_q <= bank_in;
        col_q  <= col_in;
        mask_q <= start_mask;
        left   <= start_mask;
      end else if (active) begin
        if (left == 3'd0) begin
          active <= 1'b0;
        end else begin
          left  <= left - 1'b1;
          col_q <= next_col;
        end
      end
    end
  end

  assign rd_issue = active && !is_wr;
  assign wr_issue = active && is_wr;

  // R7: successive beats stay inside the aligned block and move on
  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (active && !start_rd && !start_wr && left != 3'd0) |=>
      ((((col_q ^ $past(col_q)) & ~mext) == '0) && (col_q != $past(col_q))));

  // R9: single-location write is one beat long
  p_single_r9: assert property (@(posedge clk) disable iff (rst)
    (start_wr && wr_single) |=> (wr_issue && left == 3'd0));

  // R3: a read takes the programmed length
  p_rd_len_r3: assert property (@(posedge clk) disable iff (rst)
    start_rd |=> (rd_issue && left == $past(bl_mask)));

endmodule

// File: rtl/sdr_array.sv
module sdr_array #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic          re,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) q <= mem[addr];
  end

endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic          cl3,
  input  logic [DW-1:0] mem_q,
  output logic [DW-1:0] dq,
  output logic          vld,
  output logic          oe
);

  logic          s1v, s2v;
  logic [DW-1:0] s2d;
  logic          sel_v, pre_v;

  assign sel_v = cl3 ? s2v : s1v;
  assign pre_v = cl3 ? s1v : issue;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1v <= 1'b0;
      s2v <= 1'b0;
      s2d <= '0;
      dq  <= '0;
      vld <= 1'b0;
      oe  <= 1'b0;
    end else begin
      s1v <= issue;
      s2v <= s1v;
      s2d <= mem_q;
      dq  <= cl3 ? s2d : mem_q;
      vld <= sel_v;
      oe  <= pre_v | sel_v;
    end
  end

  // R6: the bus is driven whenever data is valid
  p_oe_cover_r6: assert property (@(posedge clk) disable iff (rst)
    vld |-> oe);

  // R5: the drive enable leads the first beat by a clock
  p_oe_lead_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(vld) |-> $past(oe));

  // R6: the drive enable closes only right after the last beat
  p_oe_close_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(oe) |-> ($past(vld) && !vld));

endmodule

// File: rtl/sdr_burst_core.sv
module sdr_burst_core #(
  parameter int BANK_W = 2,
  parameter int COL_W  = 6,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              cmd_i,
  input  logic [BANK_W-1:0]       bank_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [BANK_W+COL_W-1:0] arr_addr_o,
  output logic                    arr_we_o,
  output logic [DATA_W-1:0]       dq_o,
  output logic                    dq_valid_o,
  output logic                    dq_oe_o,
  output logic                    mode_err_o
);
  import sdr_pkg::*;

  localparam int AW = BANK_W + COL_W;

  cmd_e        cmd;
  mode_t       mode;
  logic        is_load, is_rd, is_wr;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] wd_q;
  logic [DATA_W-1:0] mem_q;
  logic        rd_issue, wr_issue;

  assign cmd     = cmd_e'(cmd_i);
  assign is_load = (cmd == CMD_LOAD);
  assign is_rd   = (cmd == CMD_READ);
  assign is_wr   = (cmd == CMD_WRITE);

  sdr_mode_reg u_mode (
    .clk  (clk),
    .rst  (rst),
    .load (is_load),
    .word (addr_i[MODE_W-1:0]),
    .mode (mode),
    .err  (mode_err_o)
  );

  sdr_burst_gen #(
    .BANK_W (BANK_W),
    .COL_W  (COL_W),
    .DATA_W (DATA_W)
  ) u_gen (
    .clk       (clk),
    .rst       (rst),
    .start_rd  (is_rd),
    .start_wr  (is_wr),
    .bank_in   (bank_i),
    .col_in    (addr_i[COL_W-1:0]),
    .wdata_in  (wdata_i),
    .bl_mask   (mode.bl_mask),
    .wr_single (mode.wr_single),
    .bank_q    (bank_q),
    .col_q     (col_q),
    .wd_q      (wd_q),
    .rd_issue  (rd_issue),
    .wr_issue  (wr_issue)
  );

  sdr_array #(
    .AW (AW),
    .DW (DATA_W)
  ) u_arr (
    .clk   (clk),
    .addr  ({bank_q, col_q}),
    .we    (wr_issue),
    .re    (rd_issue),
    .wdata (wd_q),
    .q     (mem_q)
  );

  sdr_rd_pipe #(
    .DW (DATA_W)
  ) u_pipe (
    .clk   (clk),
    .rst   (rst),
    .issue (rd_issue),
    .cl3   (mode.cl3),
    .mem_q (mem_q),
    .dq    (dq_o),
    .vld   (dq_valid_o),
    .oe    (dq_oe_o)
  );

  assign arr_addr_o = {bank_q, col_q};
  assign arr_we_o   = wr_issue;

  // R8: a write command produces a write beat on the next clock at its bank
  p_wr_start_r8: assert property (@(posedge clk) disable iff (rst)
    is_wr |=> (arr_we_o && arr_addr_o[AW-1:COL_W] == $past(bank_i)));

  // R10: a read arriving in a running read keeps the drive enable up once open
  p_seamless_r10: assert property (@(posedge clk) disable iff (rst)
    (is_rd && rd_issue && dq_oe_o) |=> dq_oe_o);

endmodule

// File: tb/sim_sdr_burst_core.sv
module sim_sdr_burst_core;
  localparam int BANK_W = 2;
  localparam int COL_W  = 6;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 10;
  localparam int AW     = BANK_W + COL_W;
  localparam int NV     = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        cmd = 2'd0;
  logic [BANK_W-1:0] bank = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [AW-1:0]     arr_addr_o;
  logic              arr_we_o;
  logic [DATA_W-1:0] dq_o;
  logic              dq_valid_o;
  logic              dq_oe_o;
  logic              mode_err_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [DATA_W-1:0] model [1 << AW];

  always #2 clk = ~clk;

  sdr_burst_core #(
    .BANK_W (BANK_W), .COL_W (COL_W), .DATA_W (DATA_W), .ADDR_W (ADDR_W)
  ) u0 (
    .clk (clk), .rst (rst), .cmd_i (cmd), .bank_i (bank), .addr_i (addr),
    .wdata_i (wdata), .arr_addr_o (arr_addr_o), .arr_we_o (arr_we_o),
    .dq_o (dq_o), .dq_valid_o (dq_valid_o), .dq_oe_o (dq_oe_o),
    .mode_err_o (mode_err_o)
  );

  // row: {tag, err, mode word, is_write, bank, col, latency, beats}
  localparam logic [29:0] VEC [NV] = '{
    {4'd5,  1'b0, 10'h020, 1'b0, 2'd0, 6'd5,  2'd2, 4'd1},
    {4'd5,  1'b0, 10'h031, 1'b0, 2'd1, 6'd7,  2'd3, 4'd2},
    {4'd7,  1'b0, 10'h022, 1'b0, 2'd2, 6'd14, 2'd2, 4'd4},
    {4'd7,  1'b0, 10'h033, 1'b0, 2'd3, 6'd61, 2'd3, 4'd8},
    {4'd8,  1'b0, 10'h023, 1'b1, 2'd0, 6'd10, 2'd2, 4'd8},
    {4'd8,  1'b0, 10'h023, 1'b0, 2'd0, 6'd8,  2'd2, 4'd8},
    {4'd9,  1'b0, 10'h232, 1'b1, 2'd1, 6'd3,  2'd3, 4'd1},
    {4'd9,  1'b0, 10'h232, 1'b0, 2'd1, 6'd1,  2'd3, 4'd4},
    {4'd8,  1'b0, 10'h022, 1'b1, 2'd2, 6'd6,  2'd2, 4'd4},
    {4'd7,  1'b0, 10'h031, 1'b0, 2'd2, 6'd4,  2'd3, 4'd2},
    {4'd2,  1'b1, 10'h052, 1'b0, 2'd0, 6'd0,  2'd3, 4'd4},
    {4'd3,  1'b1, 10'h025, 1'b0, 2'd0, 6'd0,  2'd2, 4'd4},
    {4'd4,  1'b1, 10'h0B3, 1'b0, 2'd3, 6'd0,  2'd2, 4'd4},
    {4'd4,  1'b1, 10'h133, 1'b0, 2'd3, 6'd0,  2'd2, 4'd4},
    {4'd4,  1'b1, 10'h2B3, 1'b1, 2'd3, 6'd2,  2'd2, 4'd4},
    {4'd1,  1'b0, 10'h020, 1'b0, 2'd3, 6'd2,  2'd2, 4'd1}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [COL_W-1:0] seq_col(input logic [COL_W-1:0] c,
                                               input int beats, input int j);
    logic [COL_W-1:0] m;
    m = COL_W'(beats - 1);
    return (c & ~m) | ((c + COL_W'(j)) & m);
  endfunction

  // called at a falling edge; returns at a falling edge with the bus idle
  task automatic load_mode(input logic [9:0] w);
    cmd = 2'd1;
    addr = '0;
    addr[9:0] = w;
    @(negedge clk);
    cmd = 2'd0;
  endtask

  task automatic do_read(input logic [BANK_W-1:0] b, input logic [COL_W-1:0] c,
                         input int cl, input int beats, input string req);
    cmd = 2'd2; bank = b; addr = '0; addr[COL_W-1:0] = c;
    for (int j = 0; j <= cl + beats; j++) begin
      @(negedge clk);
      if (j == 0) cmd = 2'd0;
      chk(req, "valid", dq_valid_o, (j >= cl && j < cl + beats));
      chk("R6", "drive enable", dq_oe_o, (j >= cl - 1 && j < cl + beats));
      if (j >= cl && j < cl + beats)
        chk("R7", "read data", dq_o, model[{b, seq_col(c, beats, j - cl)}]);
    end
  endtask

  task automatic do_write(input logic [BANK_W-1:0] b, input logic [COL_W-1:0] c,
                          input int beats, input logic [DATA_W-1:0] base,
                          input string req);
    cmd = 2'd3; bank = b; addr = '0; addr[COL_W-1:0] = c; wdata = base;
    for (int j = 0; j <= 8; j++) begin
      @(negedge clk);
      if (j == 0) cmd = 2'd0;
      chk(req, "write strobe", arr_we_o, (j < beats));
      if (j < beats) begin
        chk(req, "write address", arr_addr_o, {b, seq_col(c, beats, j)});
        model[{b, seq_col(c, beats, j)}] = base + DATA_W'(j);
      end
      wdata = base + DATA_W'(j + 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired, run incomplete");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "error flag", mode_err_o, 0);
    chk("R1", "valid", dq_valid_o, 0);
    chk("R1", "drive enable", dq_oe_o, 0);
    chk("R1", "write strobe", arr_we_o, 0);

    // fill the array with 8-beat writes (R8)
    load_mode(10'h023);
    for (int b = 0; b < (1 << BANK_W); b++)
      for (int c = 0; c < (1 << COL_W); c += 8)
        do_write(BANK_W'(b), COL_W'(c), 8, DATA_W'(16'h4000 + b * 256 + c * 3), "R8");

    // vector table: load, check the flag, then one access
    for (int i = 0; i < NV; i++) begin
      logic [29:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d", v[29:26]);
      load_mode(v[24:15]);
      chk(tag, "error flag after load", mode_err_o, v[25]);
      if (v[14])
        do_write(v[13:12], v[11:6], int'(v[3:0]), DATA_W'(16'hC000 + i * 16), tag);
      else
        do_read(v[13:12], v[11:6], int'(v[5:4]), int'(v[3:0]), tag);
    end

    // R10: read cut short by a second read, latency 3, 8 beats
    load_mode(10'h033);
    cmd = 2'd2; bank = 2'd0; addr = '0;
    for (int j = 0; j <= 13; j++) begin
      @(negedge clk);
      if (j == 0) cmd = 2'd0;
      if (j == 1) begin
        cmd = 2'd2; bank = 2'd1; addr = '0; addr[COL_W-1:0] = 6'd16;
      end else if (j == 2) cmd = 2'd0;
      chk("R10", "valid", dq_valid_o, (j >= 3 && j <= 12));
      chk("R10", "drive enable", dq_oe_o, (j >= 2 && j <= 12));
      if (j == 3 || j == 4)
        chk("R10", "old beat data", dq_o, model[{2'd0, COL_W'(j - 3)}]);
      if (j >= 5 && j <= 12)
        chk("R10", "new beat data", dq_o, model[{2'd1, COL_W'(16 + j - 5)}]);
    end

    // R1: reset restores defaults, array content kept
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "error flag after reset", mode_err_o, 0);
    chk("R1", "drive enable after reset", dq_oe_o, 0);
    do_read(2'd2, 6'd3, 2, 1, "R1");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule